// File: doc/BRIEF.md
# Set-Associative Cache Tag Directory

This block keeps the address-tag side of a four-way set-associative cache with 256 sets of 16-byte lines. A lookup presents a line address. Bits 11..4 of the address choose the set. Bits 31..10 form the 22-bit tag, which is compared against the tag stored in each of the four ways of that set. One cycle later the block returns the result: hit or miss, the way that matched, an error flag for more than one matching way, and the valid and updated (dirty) flags of all four ways in the set.

Three write ports change the directory.
- A refill installs a tag and marks the line valid and clean.
- A store in write-back mode marks a valid line as updated.
- An invalidate clears a line.

Bits 31..29 of the address are shadow bits, so a refill always stores them as zero. The refill port therefore carries only address bits 28..4.

There are two reset inputs, and they act differently.
- Power-on reset starts a sweep that clears the valid and updated flags of every set, one set per cycle. Lookups and writes are held off with `busy` until the sweep ends.
- Manual reset clears only the pending lookup response. It leaves the flags, the tags and the sweep untouched.

Neither reset initialises the stored tags. The data array, the bus side and the choice of victim way belong to other blocks.

Top module: `cache_tag_dir`

## Requirements
- R1: After power-on reset is released, `busy` stays 1 for exactly 256 rising edges and then falls. While `busy` is 1, lookups give no response and refill, mark and invalidate requests have no effect.
- R2: When the sweep is complete, every line is invalid and clean. Any lookup misses, with `rsp_vmask` and `rsp_umask` both 0.
- R3: A lookup is accepted on a rising edge where `lkp_req` is 1 and `busy` is 0. `rsp_vld` is 1 in the following cycle and only then.
- R4: An accepted lookup hits when a valid way of set `lkp_line[7:0]` (address bits 11..4) holds a tag equal to `lkp_line[27:6]` (address bits 31..10). In that case `rsp_hit` is 1 and `rsp_way` gives the way number in binary. Bit w of `rsp_vmask` and `rsp_umask` is the valid or updated flag of way w of that set.
- R5: A refill writes the tag `{3'b000, fill_line[24:6]}` (address bits 28..10 with bits 31..29 as zero) into set `fill_line[7:0]`, way `fill_way`. It sets the line valid and clears its updated flag. A lookup whose address bits 31..29 are not all zero therefore cannot hit.
- R6: A mark request sets the updated flag of the given set and way only if that line is valid. On an invalid line it has no effect.
- R7: An invalidate request clears both the valid and the updated flag of the given set and way.
- R8: A lookup accepted in the same cycle as a write to its set reports the contents from before the write. The write is visible to a lookup accepted one cycle later.
- R9: When writes in the same cycle target the same line, invalidate wins over refill, and refill wins over mark.
- R10: When more than one valid way matches, `rsp_multi` is 1, `rsp_hit` is 1, and `rsp_way` gives the lowest-numbered matching way.
- R11: Manual reset forces `rsp_vld` to 0 while it is low. It does not change any valid flag, updated flag or stored tag, and it does not raise `busy`.
- R12: Asserting power-on reset again restarts the sweep. Afterwards, all lines are invalid.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_pon_n | input | 1 | Power-on reset, active low, asynchronous assert |
| rst_man_n | input | 1 | Manual reset, active low, clears only the response |
| lkp_req | input | 1 | Lookup request |
| lkp_line | input | 28 | Lookup address bits 31..4 |
| fill_en | input | 1 | Refill request |
| fill_line | input | 25 | Refill address bits 28..4 |
| fill_way | input | 2 | Way written by the refill |
| mark_en | input | 1 | Mark-updated request |
| mark_set | input | 8 | Set to mark |
| mark_way | input | 2 | Way to mark |
| inval_en | input | 1 | Invalidate request |
| inval_set | input | 8 | Set to invalidate |
| inval_way | input | 2 | Way to invalidate |
| busy | output | 1 | Power-on sweep in progress |
| rsp_vld | output | 1 | Lookup response valid |
| rsp_hit | output | 1 | Lookup hit |
| rsp_way | output | 2 | Matching way, lowest on multiple match |
| rsp_multi | output | 1 | More than one valid way matched |
| rsp_vmask | output | 4 | Valid flags of the set, one per way |
| rsp_umask | output | 4 | Updated flags of the set, one per way |

## Verification
The lookup result is registered, so the bench drives a request after a falling edge and reads the response at the next falling edge. That point falls one rising edge after acceptance, and the bench's reference model produces its expected value on that same rising edge from the state it held before any write in that edge. Writes are checked through a lookup issued in the following cycle, or through a lookup in the same cycle when the test expects the old contents. The power-on sweep is measured by counting falling edges with `busy` high, starting from the falling edge at which reset is released, and the count must be 256.

// File: rtl/ctd_pkg.sv
package ctd_pkg;
  typedef enum logic {
    SWEEP_RUN  = 1'b0,
    SWEEP_DONE = 1'b1
  } sweep_e;
endpackage

// File: rtl/ctd_tag_store.sv
module ctd_tag_store #(
  parameter int SETS    = 256,
  parameter int WAYS    = 4,
  parameter int IDX_W   = 8,
  parameter int WAY_W   = 2,
  parameter int STORE_W = 19
) (
  input  logic                           clk,
  input  logic                           wr_en,
  input  logic [IDX_W-1:0]               wr_set,
  input  logic [WAY_W-1:0]               wr_way,
  input  logic [STORE_W-1:0]             wr_tag,
  input  logic [IDX_W-1:0]               rd_set,
  output logic [WAYS-1:0][STORE_W-1:0]   rd_tags
);
  // Tag payload without the shadow bits; no reset on purpose.
  logic [STORE_W-1:0] mem_q [SETS][WAYS];

  always_ff @(posedge clk) begin
    if (wr_en) mem_q[wr_set][wr_way] <= wr_tag;
  end

  for (genvar w = 0; w < WAYS; w++) begin : g_rd
    assign rd_tags[w] = mem_q[rd_set][w];
  end
endmodule

// File: rtl/ctd_flags.sv
module ctd_flags #(
  parameter int SETS  = 256,
  parameter int WAYS  = 4,
  parameter int IDX_W = 8,
  parameter int WAY_W = 2
) (
  input  logic             clk,
  input  logic             rst_pon_n,
  input  logic             fill_en,
  input  logic [IDX_W-1:0] fill_set,
  input  logic [WAY_W-1:0] fill_way,
  input  logic             mark_en,
  input  logic [IDX_W-1:0] mark_set,
  input  logic [WAY_W-1:0] mark_way,
  input  logic             inval_en,
  input  logic [IDX_W-1:0] inval_set,
  input  logic [WAY_W-1:0] inval_way,
  input  logic [IDX_W-1:0] rd_set,
  output logic [WAYS-1:0]  rd_v,
  output logic [WAYS-1:0]  rd_u,
  output logic             busy
);
  import ctd_pkg::*;

  sweep_e           st_q, st_d;
  logic [IDX_W-1:0] ptr_q, ptr_d;
  logic             mark_ok;

  logic [WAYS-1:0] v_q [SETS];
  logic [WAYS-1:0] u_q [SETS];

  // Sweep sequencer: next state
  always_comb begin
    st_d  = st_q;
    ptr_d = ptr_q;
    if (st_q == SWEEP_RUN) begin
      ptr_d = ptr_q + 1'b1;
      if (ptr_q == IDX_W'(SETS - 1)) st_d = SWEEP_DONE;
    end
  end

  // Sweep sequencer: registers, enabled only while sweeping
  always_ff @(posedge clk or negedge rst_pon_n) begin
    if (!rst_pon_n) begin
      st_q  <= SWEEP_RUN;
      ptr_q <= '0;
    end else if (st_q == SWEEP_RUN) begin
      st_q  <= st_d;
      ptr_q <= ptr_d;
    end
  end

  assign busy    = (st_q == SWEEP_RUN);
  assign mark_ok = mark_en && v_q[mark_set][mark_way];

  // Flag arrays: the sweep clears one set per cycle; later writes in
  // this process take priority (invalidate over refill over mark).
  always_ff @(posedge clk) begin
    if (busy) begin
      v_q[ptr_q] <= '0;
      u_q[ptr_q] <= '0;
    end else begin
      if (mark_ok) u_q[mark_set][mark_way] <= 1'b1;
      if (fill_en) begin
        v_q[fill_set][fill_way] <= 1'b1;
        u_q[fill_set][fill_way] <= 1'b0;
      end
      if (inval_en) begin
        v_q[inval_set][inval_way] <= 1'b0;
        u_q[inval_set][inval_way] <= 1'b0;
      end
    end
  end

  assign rd_v = v_q[rd_set];
  assign rd_u = u_q[rd_set];
endmodule

// File: rtl/ctd_match.sv
module ctd_match #(
  parameter int WAYS     = 4,
  parameter int WAY_W    = 2,
  parameter int TAG_W    = 22,
  parameter int SHADOW_W = 3,
  parameter int STORE_W  = 19
) (
  input  logic [TAG_W-1:0]             key,
  input  logic [WAYS-1:0][STORE_W-1:0] tags,
  input  logic [WAYS-1:0]              valid,
  output logic                         hit,
  output logic                         multi,
  output logic [WAY_W-1:0]             way
);
  logic [WAYS-1:0] hv;
  logic            shadow_zero;

  assign shadow_zero = (key[TAG_W-1 -: SHADOW_W] == '0);

  for (genvar w = 0; w < WAYS; w++) begin : g_cmp
    assign hv[w] = valid[w] && shadow_zero && (tags[w] == key[STORE_W-1:0]);
  end

  always_comb begin
    way = '0;
    for (int w = WAYS - 1; w >= 0; w--) begin
      if (hv[w]) way = WAY_W'(w);
    end
  end

  assign hit   = |hv;
  assign multi = ($countones(hv) > 1);
endmodule

// File: rtl/cache_tag_dir.sv
module cache_tag_dir #(
  parameter int ADDR_W   = 32,
  parameter int LINE_B   = 16,
  parameter int SETS     = 256,
  parameter int WAYS     = 4,
  parameter int TAG_LO   = 10,
  parameter int SHADOW_W = 3,
  localparam int OFF_W   = $clog2(LINE_B),
  localparam int IDX_W   = $clog2(SETS),
  localparam int WAY_W   = $clog2(WAYS),
  localparam int LINE_W  = ADDR_W - OFF_W,
  localparam int FILL_W  = LINE_W - SHADOW_W,
  localparam int TAG_W   = ADDR_W - TAG_LO,
  localparam int STORE_W = TAG_W - SHADOW_W
) (
  input  logic              clk,
  input  logic              rst_pon_n,
  input  logic              rst_man_n,
  input  logic              lkp_req,
  input  logic [LINE_W-1:0] lkp_line,
  input  logic              fill_en,
  input  logic [FILL_W-1:0] fill_line,
  input  logic [WAY_W-1:0]  fill_way,
  input  logic              mark_en,
  input  logic [IDX_W-1:0]  mark_set,
  input  logic [WAY_W-1:0]  mark_way,
  input  logic              inval_en,
  input  logic [IDX_W-1:0]  inval_set,
  input  logic [WAY_W-1:0]  inval_way,
  output logic              busy,
  output logic              rsp_vld,
  output logic              rsp_hit,
  output logic [WAY_W-1:0]  rsp_way,
  output logic              rsp_multi,
  output logic [WAYS-1:0]   rsp_vmask,
  output logic [WAYS-1:0]   rsp_umask
);
  logic                         accept, rsp_rst_n;
  logic                         fill_go, mark_go, inval_go;
  logic [IDX_W-1:0]             lkp_set;
  logic [TAG_W-1:0]             lkp_key;
  logic [WAYS-1:0][STORE_W-1:0] set_tags;
  logic [WAYS-1:0]              set_v, set_u;
  logic                         m_hit, m_multi;
  logic [WAY_W-1:0]             m_way;

  assign accept    = lkp_req && !busy;
  assign fill_go   = fill_en && !busy;
  assign mark_go   = mark_en && !busy;
  assign inval_go  = inval_en && !busy;
  assign rsp_rst_n = rst_pon_n && rst_man_n;
  assign lkp_set   = lkp_line[IDX_W-1:0];
  assign lkp_key   = lkp_line[LINE_W-1 -: TAG_W];

  ctd_tag_store #(
    .SETS(SETS), .WAYS(WAYS), .IDX_W(IDX_W), .WAY_W(WAY_W), .STORE_W(STORE_W)
  ) u_tags (
    .clk    (clk),
    .wr_en  (fill_go),
    .wr_set (fill_line[IDX_W-1:0]),
    .wr_way (fill_way),
    .wr_tag (fill_line[FILL_W-1 -: STORE_W]),
    .rd_set (lkp_set),
    .rd_tags(set_tags)
  );

  ctd_flags #(
    .SETS(SETS), .WAYS(WAYS), .IDX_W(IDX_W), .WAY_W(WAY_W)
  ) u_flags (
    .clk      (clk),
    .rst_pon_n(rst_pon_n),
    .fill_en  (fill_go),
    .fill_set (fill_line[IDX_W-1:0]),
    .fill_way (fill_way),
    .mark_en  (mark_go),
    .mark_set (mark_set),
    .mark_way (mark_way),
    .inval_en (inval_go),
    .inval_set(inval_set),
    .inval_way(inval_way),
    .rd_set   (lkp_set),
    .rd_v     (set_v),
    .rd_u     (set_u),
    .busy     (busy)
  );

  ctd_match #(
    .WAYS(WAYS), .WAY_W(WAY_W), .TAG_W(TAG_W), .SHADOW_W(SHADOW_W), .STORE_W(STORE_W)
  ) u_match (
    .key  (lkp_key),
    .tags (set_tags),
    .valid(set_v),
    .hit  (m_hit),
    .multi(m_multi),
    .way  (m_way)
  );

  // Response registers: valid every cycle, payload enabled on accept
  always_ff @(posedge clk or negedge rsp_rst_n) begin
    if (!rsp_rst_n) begin
      rsp_vld   <= 1'b0;
      rsp_hit   <= 1'b0;
      rsp_way   <= '0;
      rsp_multi <= 1'b0;
      rsp_vmask <= '0;
      rsp_umask <= '0;
    end else begin
      rsp_vld <= accept;
      if (accept) begin
        rsp_hit   <= m_hit;
        rsp_way   <= m_way;
        rsp_multi <= m_multi;
        rsp_vmask <= set_v;
        rsp_umask <= set_u;
      end
    end
  end
endmodule

// File: rtl/ctd_chk.sv
module ctd_chk #(
  parameter int SETS  = 256,
  parameter int WAYS  = 4,
  parameter int WAY_W = 2
) (
  input logic             clk,
  input logic             rst_pon_n,
  input logic             rst_man_n,
  input logic             lkp_req,
  input logic             busy,
  input logic             rsp_vld,
  input logic             rsp_hit,
  input logic [WAY_W-1:0] rsp_way,
  input logic             rsp_multi,
  input logic [WAYS-1:0]  rsp_vmask,
  input logic [WAYS-1:0]  rsp_umask
);
  localparam int CNT_W = $clog2(SETS) + 2;
  logic [CNT_W-1:0] busy_cnt;

  always_ff @(posedge clk or negedge rst_pon_n) begin
    if (!rst_pon_n) busy_cnt <= '0;
    else if (busy) busy_cnt <= busy_cnt + 1'b1;
  end

  a_r1_sweep_length: assert property (@(posedge clk) disable iff (!rst_pon_n)
    $fell(busy) |-> busy_cnt == CNT_W'(SETS));

  a_r1_no_rsp_busy: assert property (@(posedge clk) disable iff (!rst_pon_n || !rst_man_n)
    busy |=> !rsp_vld);

  a_r3_rsp_follows: assert property (@(posedge clk) disable iff (!rst_pon_n || !rst_man_n)
    (lkp_req && !busy) |=> rsp_vld);

  a_r3_no_spurious: assert property (@(posedge clk) disable iff (!rst_pon_n || !rst_man_n)
    !(lkp_req && !busy) |=> !rsp_vld);

  a_r4_hit_way_valid: assert property (@(posedge clk) disable iff (!rst_pon_n || !rst_man_n)
    (rsp_vld && rsp_hit) |-> rsp_vmask[rsp_way]);

  a_r6_dirty_needs_valid: assert property (@(posedge clk) disable iff (!rst_pon_n || !rst_man_n)
    rsp_vld |-> (rsp_umask & ~rsp_vmask) == '0);

  a_r10_multi_is_hit: assert property (@(posedge clk) disable iff (!rst_pon_n || !rst_man_n)
    (rsp_vld && rsp_multi) |-> (rsp_hit && $countones(rsp_vmask) > 1));

  a_r11_busy_stays_low: assert property (@(posedge clk) disable iff (!rst_pon_n)
    !busy |=> !busy);
endmodule

bind cache_tag_dir ctd_chk #(.SETS(SETS), .WAYS(WAYS), .WAY_W(WAY_W)) u_chk (
  .clk      (clk),
  .rst_pon_n(rst_pon_n),
  .rst_man_n(rst_man_n),
  .lkp_req  (lkp_req),
  .busy     (busy),
  .rsp_vld  (rsp_vld),
  .rsp_hit  (rsp_hit),
  .rsp_way  (rsp_way),
  .rsp_multi(rsp_multi),
  .rsp_vmask(rsp_vmask),
  .rsp_umask(rsp_umask)
);

// File: tb/tb_cache_tag_dir.sv
module tb_cache_tag_dir;
  localparam int SETS = 256;
  localparam int WAYS = 4;

  logic        clk = 1'b0;
  logic        rst_pon_n, rst_man_n;
  logic        lkp_req;
  logic [27:0] lkp_line;
  logic        fill_en;
  logic [24:0] fill_line;
  logic [1:0]  fill_way;
  logic        mark_en;
  logic [7:0]  mark_set;
  logic [1:0]  mark_way;
  logic        inval_en;
  logic [7:0]  inval_set;
  logic [1:0]  inval_way;
  logic        busy, rsp_vld, rsp_hit, rsp_multi;
  logic [1:0]  rsp_way;
  logic [3:0]  rsp_vmask, rsp_umask;

  always #4 clk = ~clk;

  cache_tag_dir dut (
    .clk(clk), .rst_pon_n(rst_pon_n), .rst_man_n(rst_man_n),
    .lkp_req(lkp_req), .lkp_line(lkp_line),
    .fill_en(fill_en), .fill_line(fill_line), .fill_way(fill_way),
    .mark_en(mark_en), .mark_set(mark_set), .mark_way(mark_way),
    .inval_en(inval_en), .inval_set(inval_set), .inval_way(inval_way),
    .busy(busy), .rsp_vld(rsp_vld), .rsp_hit(rsp_hit), .rsp_way(rsp_way),
    .rsp_multi(rsp_multi), .rsp_vmask(rsp_vmask), .rsp_umask(rsp_umask)
  );

  int    n_chk = 0;
  int    n_err = 0;
  string cur_tag = "R1";

  task automatic chk(input string t, input string what, input int act, input int exp);
    n_chk++;
    if (act != exp) begin
      n_err++;
      $display("FAIL %s %s: actual=%0h expected=%0h", t, what, act, exp);
    end
  endtask

  // Behavioural reference model
  int rt [SETS][WAYS];
  bit rv [SETS][WAYS];
  bit ru [SETS][WAYS];
  int sweep_left;
  bit e_vld, e_hit, e_multi;
  int e_way, e_vm, e_um;

  always @(posedge clk or negedge rst_pon_n or negedge rst_man_n) begin
    if (!rst_pon_n) begin
      for (int s = 0; s < SETS; s++)
        for (int w = 0; w < WAYS; w++) begin rv[s][w] = 0; ru[s][w] = 0; end
      sweep_left = SETS;
      e_vld = 0;
    end else begin
      if (clk) begin
        if (sweep_left > 0) begin
          sweep_left--;
          e_vld = 0;
        end else begin
          e_vld = lkp_req;
          if (lkp_req) begin
            int s, cnt;
            s = int'(lkp_line[7:0]);
            cnt = 0; e_vm = 0; e_um = 0; e_way = 0;
            for (int w = WAYS - 1; w >= 0; w--) begin
              if (rv[s][w]) e_vm |= (1 << w);
              if (ru[s][w]) e_um |= (1 << w);
              if (rv[s][w] && rt[s][w] == int'(lkp_line[27:6])) begin cnt++; e_way = w; end
            end
            e_hit = (cnt > 0);
            e_multi = (cnt > 1);
          end
          if (mark_en && rv[mark_set][mark_way]) ru[mark_set][mark_way] = 1;
          if (fill_en) begin
            rt[fill_line[7:0]][fill_way] = int'(fill_line[24:6]);
            rv[fill_line[7:0]][fill_way] = 1;
            ru[fill_line[7:0]][fill_way] = 0;
          end
          if (inval_en) begin
            rv[inval_set][inval_way] = 0;
            ru[inval_set][inval_way] = 0;
          end
        end
      end
      if (!rst_man_n) e_vld = 0;
    end
  end

  // Compare on every falling edge
  always @(negedge clk) begin
    if (rst_pon_n) begin
      chk(cur_tag, "busy", int'(busy), int'(sweep_left != 0));
      chk(cur_tag, "rsp_vld", int'(rsp_vld), int'(e_vld));
      if (e_vld && rsp_vld) begin
        chk(cur_tag, "rsp_hit", int'(rsp_hit), int'(e_hit));
        if (e_hit) chk(cur_tag, "rsp_way", int'(rsp_way), e_way);
        chk(cur_tag, "rsp_multi", int'(rsp_multi), int'(e_multi));
        chk(cur_tag, "rsp_vmask", int'(rsp_vmask), e_vm);
        chk(cur_tag, "rsp_umask", int'(rsp_umask), e_um);
      end
    end
  end

  task automatic idle();
    lkp_req = 0; fill_en = 0; mark_en = 0; inval_en = 0;
  endtask

  task automatic fill(input logic [31:0] a, input int w);
    fill_en = 1; fill_line = a[28:4]; fill_way = 2'(w);
    @(negedge clk); fill_en = 0;
  endtask

  task automatic mark(input logic [31:0] a, input int w);
    mark_en = 1; mark_set = a[11:4]; mark_way = 2'(w);
    @(negedge clk); mark_en = 0;
  endtask

  task automatic inval(input logic [31:0] a, input int w);
    inval_en = 1; inval_set = a[11:4]; inval_way = 2'(w);
    @(negedge clk); inval_en = 0;
  endtask

  // Lookup with explicit expectations; way checked only on hit
  task automatic look(input string t, input logic [31:0] a, input bit eh,
                      input int ew, input bit em, input int eu);
    lkp_req = 1; lkp_line = a[31:4];
    @(negedge clk);
    lkp_req = 0;
    chk(t, "vld", int'(rsp_vld), 1);
    chk(t, "hit", int'(rsp_hit), int'(eh));
    if (eh) chk(t, "way", int'(rsp_way), ew);
    chk(t, "multi", int'(rsp_multi), int'(em));
    if (eu >= 0) chk(t, "umask", int'(rsp_umask), eu);
  endtask

  task automatic pon_cycle(output int n);
    rst_pon_n = 0;
    repeat (3) @(negedge clk);
    rst_pon_n = 1;
    n = 0;
    while (busy && n < 1000) begin
      n++;
      if (n == 10) begin
        fill_en = 1; fill_line = 25'h0000_4A0; fill_way = 2'd3;
        lkp_req = 1; lkp_line = 28'h0000_4A0;
      end
      if (n == 12) idle();
      @(negedge clk);
    end
    idle();
  endtask

  localparam logic [31:0] A = 32'h0001_2350;
  localparam logic [31:0] B = 32'hE000_4470;
  localparam logic [31:0] C = 32'h0ABC_D120;
  localparam logic [31:0] D = 32'h0333_3090;

  initial begin
    int n;
    rst_pon_n = 0; rst_man_n = 1; idle();
    lkp_line = '0; fill_line = '0; fill_way = '0;
    mark_set = '0; mark_way = '0; inval_set = '0; inval_way = '0;
    repeat (2) @(negedge clk);
    chk("R1", "busy in reset", int'(busy), 1);
    chk("R3", "rsp_vld in reset", int'(rsp_vld), 0);

    cur_tag = "R1";
    pon_cycle(n);
    chk("R1", "sweep cycles", n, SETS);

    cur_tag = "R2";
    look("R2", 32'h0000_4A00, 0, 0, 0, 0);
    chk("R2", "vmask after sweep", int'(rsp_vmask), 0);
    look("R2", 32'hFFFF_FFF0, 0, 0, 0, 0);

    cur_tag = "R4";
    fill(A, 2);
    look("R4", A, 1, 2, 0, 0);
    chk("R4", "vmask", int'(rsp_vmask), 4'b0100);

    cur_tag = "R5";
    fill(B, 1);
    look("R5", B, 0, 0, 0, -1);
    look("R5", B & 32'h1FFF_FFFF, 1, 1, 0, 0);

    cur_tag = "R6";
    mark(A, 2);
    look("R6", A, 1, 2, 0, 4'b0100);
    mark(A, 0);
    look("R6", A, 1, 2, 0, 4'b0100);

    cur_tag = "R7";
    inval(A, 2);
    look("R7", A, 0, 0, 0, 0);
    chk("R7", "vmask", int'(rsp_vmask), 0);

    cur_tag = "R8";
    fill_en = 1; fill_line = C[28:4]; fill_way = 2'd0;
    look("R8", C, 0, 0, 0, 0);
    fill_en = 0;
    look("R8", C, 1, 0, 0, 0);

    cur_tag = "R9";
    fill_en = 1; fill_line = D[28:4]; fill_way = 2'd2;
    inval_en = 1; inval_set = D[11:4]; inval_way = 2'd2;
    @(negedge clk); idle();
    look("R9", D, 0, 0, 0, 0);
    fill(D, 1);
    mark_en = 1; mark_set = D[11:4]; mark_way = 2'd1;
    fill_en = 1; fill_line = D[28:4]; fill_way = 2'd1;
    @(negedge clk); idle();
    look("R9", D, 1, 1, 0, 0);

    cur_tag = "R10";
    fill(D, 3);
    look("R10", D, 1, 1, 1, 0);
    inval(D, 1);
    fill(D, 0);
    look("R10", D, 1, 0, 1, 0);

    cur_tag = "R11";
    mark(D, 3);
    lkp_req = 1; lkp_line = D[31:4];
    rst_man_n = 0;
    repeat (3) begin
      @(negedge clk);
      chk("R11", "rsp_vld in manual reset", int'(rsp_vld), 0);
      chk("R11", "busy in manual reset", int'(busy), 0);
    end
    rst_man_n = 1; idle();
    @(negedge clk);
    look("R11", D, 1, 0, 1, 4'b1000);
    look("R11", C, 1, 0, 0, 0);

    cur_tag = "R3";
    for (int i = 0; i < 3000; i++) begin
      lkp_req   = ($urandom % 2) == 0;
      lkp_line  = {($urandom % 8) == 0 ? 3'b101 : 3'b000, 23'($urandom % 4) << 2, 2'b00} |
                  28'($urandom % 4);
      fill_en   = ($urandom % 4) == 0;
      fill_line = 25'(($urandom % 4) << 6) | 25'($urandom % 4);
      fill_way  = 2'($urandom);
      mark_en   = ($urandom % 4) == 0;
      mark_set  = 8'($urandom % 4);
      mark_way  = 2'($urandom);
      inval_en  = ($urandom % 6) == 0;
      inval_set = 8'($urandom % 4);
      inval_way = 2'($urandom);
      @(negedge clk);
    end
    idle();
    @(negedge clk);

    cur_tag = "R12";
    pon_cycle(n);
    chk("R12", "second sweep cycles", n, SETS);
    look("R12", D, 0, 0, 0, 0);
    look("R12", C, 0, 0, 0, 0);
    chk("R12", "vmask", int'(rsp_vmask), 0);
    look("R12", 32'h0000_4A00, 0, 0, 0, 0);

    $display("Simulation finished: %0d checks, %0d errors", n_chk, n_err);
    $finish;
  end

  initial begin
    repeat (200000) @(posedge clk);
    n_chk++;
    n_err++;
    $display("FAIL watchdog: actual=timeout expected=completion");
    $display("Simulation finished: %0d checks, %0d errors", n_chk, n_err);
    $finish;
  end
endmodule